// File: doc/BRIEF.md
# Lockable Memory Carveout Access Checker

This block guards a single protected window of physical address space inside a memory controller. Software programs a window base, a window size, one 32-bit configuration word and five 32-bit whitelist words through a small register write port. Every memory request presented to the block carries a client number, a direction (read or write), a two-bit privilege level, an address, a flag telling whether the address came through translation, a secure-world flag and a three-bit aperture tag. One cycle later the block answers allow or deny.

A request that falls outside the window is always allowed. A request inside it is allowed when a secure-world bypass applies, when its client's whitelist bit is set, or when its privilege level passes the level check for its direction. Anything else is denied, and the first denied client is recorded behind a sticky violation flag. A lock bit in the configuration word freezes all settings until reset. A protect bit lets secure-world writers keep updating them after lockdown.

The register indices are: 0 window base, 1 window size, 2 configuration word, 3 to 7 whitelist words 0 to 4.

Top module: `carveout_guard`

## Requirements
- R1: A request hits the window when base <= address and address - base < size, computed modulo 2^ADDR_W, so a window may end exactly at the top of the address space. A size of 0 gives no hit. A request that misses is always allowed.
- R2: Configuration bit 2 is address-type select. When it is 1, a request flagged translated never hits. When it is 0, translation has no effect on the hit test.
- R3: Configuration bits 13:11 hold a window aperture tag. When bit 26 (strict) is 1 and bit 25 (any) is 0, only requests whose aperture tag equals it can hit. When bit 26 is 0 or bit 25 is 1, the aperture tag does not take part in the hit test.
- R4: Whitelist word k (register index 3+k) bit j grants client 32*k+j, for both directions. Client numbers 160 and above have no whitelist bit and are never granted by it.
- R5: Configuration bits 6:3 are the read level mask and bits 10:7 the write level mask. Mask bit n grants a hitting request of that direction at level n.
- R6: Configuration bits 17:14 (read) and 21:18 (write) disable the level check per level. A disabled level passes the level check for that direction whatever the mask holds.
- R7: Configuration bit 23 allows every hitting secure-world write and bit 24 every hitting secure-world read, with no other check.
- R8: A hitting request that no rule grants is denied. The first denial sets a sticky violation flag and captures that request's client number. Both stay unchanged until reset.
- R9: The response is registered. resp_valid is 1 exactly in the cycle after a cycle with req_valid, and resp_allow holds the decision for that request.
- R10: Configuration bit 1 is the lock bit. While it is 1, register writes are ignored, unless configuration bit 0 (protect) is 1 and the write is flagged secure-world.
- R11: After reset all registers are zero: unlocked, empty window, no levels, empty whitelist, violation flag and client clear, no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 3 | Register index (0 base, 1 size, 2 config, 3..7 whitelist) |
| cfg_wr_data | input | 32 | Register write data |
| cfg_wr_secure | input | 1 | Write comes from the secure world |
| req_valid | input | 1 | Request present |
| req_client | input | CLIENT_W | Requesting client number |
| req_write | input | 1 | 1 write, 0 read |
| req_level | input | 2 | Request privilege level 0..3 |
| req_addr | input | ADDR_W | Physical request address |
| req_translated | input | 1 | Address came through translation |
| req_secure | input | 1 | Request from the secure world |
| req_aperture | input | 3 | Request aperture tag |
| resp_valid | output | 1 | Decision valid (one cycle after request) |
| resp_allow | output | 1 | 1 allow, 0 deny |
| viol_flag | output | 1 | Sticky violation flag |
| viol_client | output | CLIENT_W | Client of the first denied request |

## Verification
The bench builds the block with its defaults: a 32-bit address, an 8-bit client number and five whitelist words. The 32-bit address allows a window whose last byte is the top of the address space, where base + size wraps to zero. The 8-bit client number reaches client numbers 160 to 255, which lie past the 160-bit whitelist. The five words put the whitelist edge at client 159, so the last valid bit and the first missing one can both be probed. Each level rule, bypass, aperture mode and lock mode is then exercised on both sides of its decision.

// File: rtl/carveout_pkg.sv
package carveout_pkg;
    localparam int REG_W        = 32;
    localparam int NUM_LEVELS   = 4;
    localparam int APER_W       = 3;
    localparam int REG_IDX_W    = 3;

    // register indices
    localparam int REG_BASE     = 0;
    localparam int REG_SIZE     = 1;
    localparam int REG_CFG      = 2;
    localparam int REG_WL0      = 3;

    // configuration word field positions
    localparam int CFG_PROTECT    = 0;
    localparam int CFG_LOCK       = 1;
    localparam int CFG_UNTR_ONLY  = 2;
    localparam int CFG_RD_MASK_LO = 3;
    localparam int CFG_WR_MASK_LO = 7;
    localparam int CFG_APER_LO    = 11;
    localparam int CFG_RD_DIS_LO  = 14;
    localparam int CFG_WR_DIS_LO  = 18;
    localparam int CFG_SEC_WR_BYP = 23;
    localparam int CFG_SEC_RD_BYP = 24;
    localparam int CFG_APER_ANY   = 25;
    localparam int CFG_APER_STRICT= 26;

    typedef enum logic [1:0] {
        VERD_MISS   = 2'd0,
        VERD_BYPASS = 2'd1,
        VERD_GRANT  = 2'd2,
        VERD_DENY   = 2'd3
    } verdict_e;
endpackage

// File: rtl/carveout_regs.sv
module carveout_regs
    import carveout_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WL_WORDS = 5,
    localparam int WL_BITS = WL_WORDS * REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [REG_IDX_W-1:0] wr_idx_i,
    input  logic [REG_W-1:0]     wr_data_i,
    input  logic                 wr_secure_i,
    output logic [ADDR_W-1:0]    base_o,
    output logic [ADDR_W-1:0]    size_o,
    output logic [REG_W-1:0]     cfg_o,
    output logic [WL_BITS-1:0]   wl_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  size;
        logic [REG_W-1:0]   cfg;
        logic [WL_BITS-1:0] wl;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_ok;

    always_comb begin
        // lockdown: frozen unless protect mode admits a secure writer
        wr_ok = !st_q.cfg[CFG_LOCK] ||
                (st_q.cfg[CFG_PROTECT] && wr_secure_i);
        st_d  = st_q;
        if (wr_en_i && wr_ok) begin
            case (int'(wr_idx_i))
                REG_BASE: st_d.base = ADDR_W'(wr_data_i);
                REG_SIZE: st_d.size = ADDR_W'(wr_data_i);
                REG_CFG:  st_d.cfg  = wr_data_i;
                default:  ;
            endcase
            for (int k = 0; k < WL_WORDS; k++) begin
                if (int'(wr_idx_i) == REG_WL0 + k)
                    st_d.wl[k*REG_W +: REG_W] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;
    assign size_o = st_q.size;
    assign cfg_o  = st_q.cfg;
    assign wl_o   = st_q.wl;
endmodule

// File: rtl/carveout_hit.sv
module carveout_hit
    import carveout_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              translated_i,
    input  logic [APER_W-1:0] req_aper_i,
    input  logic              untr_only_i,
    input  logic [APER_W-1:0] win_aper_i,
    input  logic              aper_any_i,
    input  logic              aper_strict_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic              type_ok;
    logic              aper_ok;

    always_comb begin
        // one subtractor + one compare; wraps cleanly at the top of space
        offset   = addr_i - base_i;
        in_range = (addr_i >= base_i) && (offset < size_i);
        type_ok  = !(untr_only_i && translated_i);
        aper_ok  = aper_any_i || !aper_strict_i || (req_aper_i == win_aper_i);
        hit_o    = in_range && type_ok && aper_ok;
    end
endmodule

// File: rtl/carveout_policy.sv
module carveout_policy
    import carveout_pkg::*;
#(
    parameter int CLIENT_W = 8,
    parameter int WL_BITS  = 160,
    localparam int WL_IDX_W = $clog2(WL_BITS),
    localparam int LVL_W    = $clog2(NUM_LEVELS)
) (
    input  logic                  hit_i,
    input  logic [CLIENT_W-1:0]   client_i,
    input  logic                  write_i,
    input  logic [LVL_W-1:0]      level_i,
    input  logic                  secure_i,
    input  logic [WL_BITS-1:0]    wl_i,
    input  logic [NUM_LEVELS-1:0] rd_mask_i,
    input  logic [NUM_LEVELS-1:0] wr_mask_i,
    input  logic [NUM_LEVELS-1:0] rd_dis_i,
    input  logic [NUM_LEVELS-1:0] wr_dis_i,
    input  logic                  sec_wr_byp_i,
    input  logic                  sec_rd_byp_i,
    output verdict_e              verdict_o
);
    logic                  wl_hit;
    logic                  lvl_ok;
    logic                  bypass;
    logic [NUM_LEVELS-1:0] lvl_pass;

    // per-level pass vector: mask grant or check disabled, per direction
    for (genvar n = 0; n < NUM_LEVELS; n++) begin : g_lvl
        assign lvl_pass[n] = write_i ? (wr_mask_i[n] | wr_dis_i[n])
                                     : (rd_mask_i[n] | rd_dis_i[n]);
    end

    always_comb begin
        if (int'(client_i) < WL_BITS)
            wl_hit = wl_i[WL_IDX_W'(client_i)];
        else
            wl_hit = 1'b0;
        lvl_ok = lvl_pass[level_i];
        bypass = secure_i && (write_i ? sec_wr_byp_i : sec_rd_byp_i);

        if (!hit_i)                verdict_o = VERD_MISS;
        else if (bypass)           verdict_o = VERD_BYPASS;
        else if (wl_hit || lvl_ok) verdict_o = VERD_GRANT;
        else                       verdict_o = VERD_DENY;
    end
endmodule

// File: rtl/carveout_guard.sv
module carveout_guard
    import carveout_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CLIENT_W = 8,
    parameter int WL_WORDS = 5,
    localparam int WL_BITS = WL_WORDS * REG_W,
    localparam int LVL_W   = $clog2(NUM_LEVELS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [REG_IDX_W-1:0] cfg_wr_idx,
    input  logic [REG_W-1:0]     cfg_wr_data,
    input  logic                 cfg_wr_secure,
    input  logic                 req_valid,
    input  logic [CLIENT_W-1:0]  req_client,
    input  logic                 req_write,
    input  logic [LVL_W-1:0]     req_level,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_translated,
    input  logic                 req_secure,
    input  logic [APER_W-1:0]    req_aperture,
    output logic                 resp_valid,
    output logic                 resp_allow,
    output logic                 viol_flag,
    output logic [CLIENT_W-1:0]  viol_client
);
    typedef struct packed {
        logic                resp_valid;
        logic                resp_allow;
        logic                viol_flag;
        logic [CLIENT_W-1:0] viol_client;
    } out_t;

    logic [ADDR_W-1:0]  base_w;
    logic [ADDR_W-1:0]  size_w;
    logic [REG_W-1:0]   cfg_w;
    logic [WL_BITS-1:0] wl_w;
    logic               hit_w;
    verdict_e           verdict_w;
    logic               allow_w;
    logic               unused_cfg_bits;
    out_t               o_d, o_q;

    carveout_regs #(
        .ADDR_W   (ADDR_W),
        .WL_WORDS (WL_WORDS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cfg_wr_en),
        .wr_idx_i    (cfg_wr_idx),
        .wr_data_i   (cfg_wr_data),
        .wr_secure_i (cfg_wr_secure),
        .base_o      (base_w),
        .size_o      (size_w),
        .cfg_o       (cfg_w),
        .wl_o        (wl_w)
    );

    carveout_hit #(
        .ADDR_W (ADDR_W)
    ) u_hit (
        .base_i        (base_w),
        .size_i        (size_w),
        .addr_i        (req_addr),
        .translated_i  (req_translated),
        .req_aper_i    (req_aperture),
        .untr_only_i   (cfg_w[CFG_UNTR_ONLY]),
        .win_aper_i    (cfg_w[CFG_APER_LO +: APER_W]),
        .aper_any_i    (cfg_w[CFG_APER_ANY]),
        .aper_strict_i (cfg_w[CFG_APER_STRICT]),
        .hit_o         (hit_w)
    );

    carveout_policy #(
        .CLIENT_W (CLIENT_W),
        .WL_BITS  (WL_BITS)
    ) u_policy (
        .hit_i        (hit_w),
        .client_i     (req_client),
        .write_i      (req_write),
        .level_i      (req_level),
        .secure_i     (req_secure),
        .wl_i         (wl_w),
        .rd_mask_i    (cfg_w[CFG_RD_MASK_LO +: NUM_LEVELS]),
        .wr_mask_i    (cfg_w[CFG_WR_MASK_LO +: NUM_LEVELS]),
        .rd_dis_i     (cfg_w[CFG_RD_DIS_LO +: NUM_LEVELS]),
        .wr_dis_i     (cfg_w[CFG_WR_DIS_LO +: NUM_LEVELS]),
        .sec_wr_byp_i (cfg_w[CFG_SEC_WR_BYP]),
        .sec_rd_byp_i (cfg_w[CFG_SEC_RD_BYP]),
        .verdict_o    (verdict_w)
    );

    // bits held in the word but not consumed by the decision path
    assign unused_cfg_bits = ^{cfg_w[REG_W-1:CFG_APER_STRICT+1], cfg_w[22],
                               cfg_w[CFG_LOCK], cfg_w[CFG_PROTECT]};

    assign allow_w = (verdict_w != VERD_DENY);

    always_comb begin
        o_d            = o_q;
        o_d.resp_valid = req_valid;
        o_d.resp_allow = req_valid && allow_w;
        if (req_valid && !allow_w && !o_q.viol_flag) begin
            o_d.viol_flag   = 1'b1;
            o_d.viol_client = req_client;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign resp_valid  = o_q.resp_valid;
    assign resp_allow  = o_q.resp_allow;
    assign viol_flag   = o_q.viol_flag;
    assign viol_client = o_q.viol_client;
endmodule

// File: rtl/carveout_guard_chk.sv
module carveout_guard_chk
    import carveout_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CLIENT_W = 8,
    parameter int WL_BITS  = 160
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic                req_secure,
    input logic                req_translated,
    input logic                cfg_wr_secure,
    input logic                hit_w,
    input logic                resp_valid,
    input logic                resp_allow,
    input logic                viol_flag,
    input logic [CLIENT_W-1:0] viol_client,
    input logic [REG_W-1:0]    cfg_w,
    input logic [ADDR_W-1:0]   base_w,
    input logic [ADDR_W-1:0]   size_w,
    input logic [WL_BITS-1:0]  wl_w
);
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R9
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R9
    AST_MISS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit_w) |=> resp_allow); // R1
    AST_TRANSLATED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w[CFG_UNTR_ONLY] && req_translated) |-> !hit_w); // R2
    AST_SEC_WR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secure && req_write && cfg_w[CFG_SEC_WR_BYP]) |=> resp_allow); // R7
    AST_SEC_RD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_secure && !req_write && cfg_w[CFG_SEC_RD_BYP]) |=> resp_allow); // R7
    AST_DENY_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_allow) |-> viol_flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> (viol_flag && $stable(viol_client))); // R8
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w[CFG_LOCK] && !(cfg_w[CFG_PROTECT] && cfg_wr_secure))
        |=> ($stable(cfg_w) && $stable(base_w) && $stable(size_w) && $stable(wl_w))); // R10
endmodule

bind carveout_guard carveout_guard_chk #(
    .ADDR_W   (ADDR_W),
    .CLIENT_W (CLIENT_W),
    .WL_BITS  (WL_BITS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_secure     (req_secure),
    .req_translated (req_translated),
    .cfg_wr_secure  (cfg_wr_secure),
    .hit_w          (hit_w),
    .resp_valid     (resp_valid),
    .resp_allow     (resp_allow),
    .viol_flag      (viol_flag),
    .viol_client    (viol_client),
    .cfg_w          (cfg_w),
    .base_w         (base_w),
    .size_w         (size_w),
    .wl_w           (wl_w)
);

// File: tb/carveout_guard_tb.sv
module carveout_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_wr_secure = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_client = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_level = '0;
    logic [31:0] req_addr = '0;
    logic        req_translated = 1'b0;
    logic        req_secure = 1'b0;
    logic [2:0]  req_aperture = '0;
    logic        resp_valid;
    logic        resp_allow;
    logic        viol_flag;
    logic [7:0]  viol_client;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    carveout_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_data(cfg_wr_data), .cfg_wr_secure(cfg_wr_secure),
        .req_valid(req_valid), .req_client(req_client), .req_write(req_write),
        .req_level(req_level), .req_addr(req_addr),
        .req_translated(req_translated), .req_secure(req_secure),
        .req_aperture(req_aperture),
        .resp_valid(resp_valid), .resp_allow(resp_allow),
        .viol_flag(viol_flag), .viol_client(viol_client)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(int idx, logic [31:0] data, bit sec);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = 3'(idx);
        cfg_wr_data = data; cfg_wr_secure = sec;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wr_secure = 1'b0;
    endtask

    // drive one request, sample the registered answer one cycle later
    task automatic do_req(string tag, bit exp_allow, logic [7:0] cl, bit wr,
                          logic [1:0] lvl, logic [31:0] addr,
                          bit trans = 0, bit sec = 0, logic [2:0] aper = 3'd0);
        @(negedge clk);
        req_valid = 1'b1; req_client = cl; req_write = wr; req_level = lvl;
        req_addr = addr; req_translated = trans; req_secure = sec;
        req_aperture = aper;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " resp_valid"}, 64'(resp_valid), 64'd1);
        check(tag, 64'(resp_allow), 64'(exp_allow));
    endtask

    task automatic set_window(logic [31:0] base, logic [31:0] size);
        wr_reg(0, base, 0);
        wr_reg(1, size, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 resp_valid after reset", 64'(resp_valid), 64'd0);
        check("R11 viol_flag after reset", 64'(viol_flag), 64'd0);
        check("R11 viol_client after reset", 64'(viol_client), 64'd0);
        do_req("R11 empty window allows", 1, 8'h07, 1, 2'd0, 32'h0);
        check("R11 no violation", 64'(viol_flag), 64'd0);
    endtask

    task automatic t_latency();
        do_reset();
        do_req("R9 single request", 1, 8'h01, 0, 2'd0, 32'h40);
        @(negedge clk);
        check("R9 resp_valid drops after idle", 64'(resp_valid), 64'd0);
        check("R9 resp_allow low when idle", 64'(resp_allow), 64'd0);
    endtask

    task automatic t_window();
        do_reset();
        set_window(32'h1000, 32'h100);
        do_req("R1 below base allowed", 1, 8'h10, 0, 2'd0, 32'h0FFF);
        check("R8 no flag on miss", 64'(viol_flag), 64'd0);
        do_req("R1 base hits and denies", 0, 8'h21, 0, 2'd0, 32'h1000);
        check("R8 flag raised", 64'(viol_flag), 64'd1);
        check("R8 first client captured", 64'(viol_client), 64'h21);
        do_req("R1 last byte hits", 0, 8'h22, 1, 2'd3, 32'h10FF);
        check("R8 client kept", 64'(viol_client), 64'h21);
        do_req("R1 end address misses", 1, 8'h23, 0, 2'd0, 32'h1100);
        set_window(32'hFFFF_FF00, 32'h100);
        do_req("R1 top of space hits", 0, 8'h24, 0, 2'd0, 32'hFFFF_FFFF);
        do_req("R1 just below top window", 1, 8'h24, 0, 2'd0, 32'hFFFF_FEFF);
        wr_reg(1, 32'h0, 0);
        do_req("R1 zero size never hits", 1, 8'h24, 0, 2'd0, 32'hFFFF_FF00);
        check("R8 client still first", 64'(viol_client), 64'h21);
    endtask

    task automatic t_levels();
        do_reset();
        set_window(32'h2000, 32'h1000);
        wr_reg(2, 32'h0000_0120, 0); // read level 2, write level 1
        do_req("R5 read lvl2 granted", 1, 8'h30, 0, 2'd2, 32'h2010);
        do_req("R5 read lvl1 denied", 0, 8'h30, 0, 2'd1, 32'h2010);
        do_req("R5 write lvl1 granted", 1, 8'h30, 1, 2'd1, 32'h2010);
        do_req("R5 write lvl2 denied", 0, 8'h30, 1, 2'd2, 32'h2010);
        do_req("R5 read lvl0 denied", 0, 8'h30, 0, 2'd0, 32'h2FFF);
    endtask

    task automatic t_disables();
        do_reset();
        set_window(32'h2000, 32'h1000);
        wr_reg(2, 32'h0006_0000, 0); // read-disable lvl3, write-disable lvl0
        do_req("R6 read lvl3 check off", 1, 8'h31, 0, 2'd3, 32'h2100);
        do_req("R6 write lvl3 still checked", 0, 8'h31, 1, 2'd3, 32'h2100);
        do_req("R6 write lvl0 check off", 1, 8'h31, 1, 2'd0, 32'h2100);
        do_req("R6 read lvl0 still checked", 0, 8'h31, 0, 2'd0, 32'h2100);
    endtask

    task automatic t_whitelist();
        do_reset();
        set_window(32'h2000, 32'h1000);
        wr_reg(7, 32'h8000_0000, 0); // client 159
        wr_reg(3, 32'h0000_0020, 0); // client 5
        do_req("R4 client 159 granted", 1, 8'd159, 0, 2'd0, 32'h2200);
        do_req("R4 client 158 denied", 0, 8'd158, 0, 2'd0, 32'h2200);
        do_req("R4 client 5 write granted", 1, 8'd5, 1, 2'd3, 32'h2200);
        do_req("R4 client 4 denied", 0, 8'd4, 1, 2'd3, 32'h2200);
        wr_reg(7, 32'hFFFF_FFFF, 0);
        do_req("R4 client 128 granted", 1, 8'd128, 1, 2'd1, 32'h2200);
        do_req("R4 client 200 outside list", 0, 8'd200, 0, 2'd0, 32'h2200);
    endtask

    task automatic t_bypass();
        do_reset();
        set_window(32'h3000, 32'h100);
        wr_reg(2, 32'h0080_0000, 0); // secure write bypass
        do_req("R7 secure write bypassed", 1, 8'h40, 1, 2'd0, 32'h3000, 0, 1);
        do_req("R7 nonsecure write denied", 0, 8'h40, 1, 2'd0, 32'h3000, 0, 0);
        do_req("R7 secure read not bypassed", 0, 8'h40, 0, 2'd0, 32'h3000, 0, 1);
        wr_reg(2, 32'h0100_0000, 0); // secure read bypass
        do_req("R7 secure read bypassed", 1, 8'h40, 0, 2'd0, 32'h3000, 0, 1);
        do_req("R7 secure write not bypassed", 0, 8'h40, 1, 2'd0, 32'h3000, 0, 1);
    endtask

    task automatic t_addr_type();
        do_reset();
        set_window(32'h3000, 32'h100);
        do_req("R2 translated hits when any", 0, 8'h41, 0, 2'd0, 32'h3010, 1);
        wr_reg(2, 32'h0000_0004, 0);
        do_req("R2 translated skips window", 1, 8'h41, 0, 2'd0, 32'h3010, 1);
        do_req("R2 untranslated still hits", 0, 8'h41, 0, 2'd0, 32'h3010, 0);
    endtask

    task automatic t_aperture();
        do_reset();
        set_window(32'h3000, 32'h100);
        wr_reg(2, 32'h0000_2800, 0); // tag 5, no aperture mode
        do_req("R3 tag ignored by default", 0, 8'h42, 0, 2'd0, 32'h3000, 0, 0, 3'd3);
        wr_reg(2, 32'h0400_2800, 0); // strict
        do_req("R3 strict mismatch misses", 1, 8'h42, 0, 2'd0, 32'h3000, 0, 0, 3'd3);
        do_req("R3 strict match hits", 0, 8'h42, 0, 2'd0, 32'h3000, 0, 0, 3'd5);
        wr_reg(2, 32'h0600_2800, 0); // strict + any
        do_req("R3 any overrides strict", 0, 8'h42, 0, 2'd0, 32'h3000, 0, 0, 3'd3);
    endtask

    task automatic t_lock();
        do_reset();
        set_window(32'h1000, 32'h100);
        wr_reg(2, 32'h0000_0002, 0); // lock, protect 0
        wr_reg(0, 32'h8000, 0);
        wr_reg(0, 32'h8000, 1);
        do_req("R10 locked base unchanged", 0, 8'h50, 0, 2'd0, 32'h1000);
        do_req("R10 new base not applied", 1, 8'h50, 0, 2'd0, 32'h8000);
        wr_reg(2, 32'h0000_0000, 1);
        wr_reg(0, 32'h8000, 0);
        do_req("R10 unlock write ignored", 0, 8'h50, 0, 2'd0, 32'h1000);
        do_reset();
        set_window(32'h1000, 32'h100);
        wr_reg(2, 32'h0000_0003, 0); // lock, protect 1
        wr_reg(0, 32'h8000, 0);
        do_req("R10 nonsecure write ignored", 0, 8'h51, 0, 2'd0, 32'h1000);
        wr_reg(0, 32'h8000, 1);
        do_req("R10 secure write moved base", 1, 8'h51, 0, 2'd0, 32'h1000);
        do_req("R10 window at new base", 0, 8'h51, 0, 2'd0, 32'h8000);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_window();
        t_levels();
        t_disables();
        t_whitelist();
        t_bypass();
        t_addr_type();
        t_aperture();
        t_lock();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule